// File: doc/BRIEF.md
# Serial Command-Byte Register Interface

This block is the device side of a synchronous serial link into a small register file. The serial clock is the block clock. A host opens every transaction with an 8-bit command byte, sent most significant bit first. The byte names one of eight register addresses and says whether the host will read or write. The block then takes in or sends out exactly as many bits as the addressed register holds, and goes back to waiting for the next command byte. Input bits are taken on the rising edge and the output bit changes on the falling edge.

A conversion engine sits beside the block and is not part of it. It drops a fresh 24-bit result into the data register through a load strobe, and the active-low ready flag falls. Reading the data register raises the flag again. A continuous-read mode lets the host pull each new result just by clocking, with no command byte. Thirty-two ones in a row on the data input act as a resynchronisation reset. They return the interface and every register to its default state.

Top module: `sercmd_if`

## Requirements
- R1: A command byte is shifted in MSB first. Its layout is: bit 7 = write-enable (must be 0), bit 6 = direction (1 read, 0 write), bits 5..3 = address, bit 2 = continuous-read, bits 1..0 = 0. While the bit seen at the first position is 1, the interface stays at that position. Only a 0 there starts the seven further command bits.
- R2: A write command is followed by data bits, MSB first, at the register's width. On the last data bit the register takes the value. Address 1 (16 bits) appears on `mode_q`, address 2 (16 bits) on `conf_q`, address 6 (24 bits) on `offs_q` and address 7 (24 bits) on `fscale_q`.
- R3: A read command is followed by the register value on `dout`, MSB first, at the register's width. The first bit is valid from the falling edge after the last command bit. Each bit is held until the next falling edge.
- R4: The read values are as follows. Address 0 gives 8 bits, with bit 7 equal to `rdy_n` and the rest zero. Address 4 gives the 8-bit constant 0x5B. Address 5 gives 8 bits of zeros. Address 3 gives the 24-bit conversion result.
- R5: A write to address 5 (8 data bits) is consumed and changes no register. A write command to address 0 carries no data phase.
- R6: After each completed access the interface is ready for a new command byte on the very next clock, with no idle bits needed.
- R7: A `conv_load` pulse stores `conv_data` and drives `rdy_n` low on the following cycle. Starting a read of address 3 drives `rdy_n` high.
- R8: The exact command 0x5C enters continuous-read mode. After that, each time `rdy_n` is low, the next clock starts a 24-bit output of the data register with no command byte. The output's first bit is on `dout` from the falling edge after that clock.
- R9: In continuous-read mode, the first eight input bits of an output frame are watched. If they equal 0x58, the interface returns to command waiting once the frame ends.
- R10: Thirty-two consecutive ones on `din` reset the interface state and all registers to their defaults, in any mode. Thirty-one ones followed by a zero do not.
- R11: Synchronous reset `rst` gives: `rdy_n` = 1, `dout` = 0, mode 0x000A, configuration 0x0710, offset 0x800000, full-scale 0x500000, and command waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial clock, also the block clock |
| rst | input | 1 | Synchronous active-high reset |
| din | input | 1 | Serial data from host, sampled on rising edge |
| conv_load | input | 1 | Strobe that stores a new conversion result |
| conv_data | input | 24 | Conversion result stored on `conv_load` |
| dout | output | 1 | Serial data to host, updated on falling edge |
| rdy_n | output | 1 | Low while an unread conversion result is held |
| mode_q | output | 16 | Mode register contents |
| conf_q | output | 16 | Configuration register contents |
| offs_q | output | 24 | Offset register contents |
| fscale_q | output | 24 | Full-scale register contents |

## Verification
The bench feeds leading ones before a command. A design that shifted them in would misread the following read of the ID register. It puts register widths of 8, 16 and 24 bits back to back with no idle bits, so a wrong width table or a late return to command waiting shows up as corrupted words. A write to the reserved address is followed by checks of the other registers, which catches a decoder that aliases it. Continuous-read frames are pulled after separate loads, and one frame carries the exit byte. A design that ignores it still swallows the next command, and one that ignores the ready flag shifts stale data. Runs of exactly thirty-one and thirty-two ones probe the resynchronisation count from both sides. The second run is also sent from inside continuous-read mode.

// File: rtl/sif_pkg.sv
package sif_pkg;
    localparam int DATA_W = 24;
    localparam int CMD_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    localparam logic [2:0] A_COMM  = 3'd0;
    localparam logic [2:0] A_MODE  = 3'd1;
    localparam logic [2:0] A_CONF  = 3'd2;
    localparam logic [2:0] A_DATA  = 3'd3;
    localparam logic [2:0] A_IDENT = 3'd4;
    localparam logic [2:0] A_RSVD  = 3'd5;
    localparam logic [2:0] A_OFFS  = 3'd6;
    localparam logic [2:0] A_FSCL  = 3'd7;

    localparam logic [7:0]  CREAD_ENTER = 8'h5C;
    localparam logic [7:0]  CREAD_LEAVE = 8'h58;
    localparam logic [7:0]  IDENT_VAL   = 8'h5B;
    localparam logic [15:0] MODE_DEF    = 16'h000A;
    localparam logic [15:0] CONF_DEF    = 16'h0710;
    localparam logic [23:0] OFFS_DEF    = 24'h800000;
    localparam logic [23:0] FSCL_DEF    = 24'h500000;

    typedef enum logic [2:0] {
        S_CMD, S_WR, S_RD, S_CRWAIT, S_CRRD
    } state_e;

    typedef struct packed {
        logic       wen;
        logic       rd;
        logic [2:0] addr;
        logic       cread;
        logic [1:0] pad;
    } cmd_t;

    function automatic logic [CNT_W-1:0] reg_bits(input logic [2:0] a);
        case (a)
            A_MODE, A_CONF:         reg_bits = CNT_W'(16);
            A_DATA, A_OFFS, A_FSCL: reg_bits = CNT_W'(24);
            default:                reg_bits = CNT_W'(8);
        endcase
    endfunction
endpackage

// File: rtl/sif_ones_watch.sv
module sif_ones_watch #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic fire
);
    localparam int RW = $clog2(RUN_LEN);
    logic [RW-1:0] run_q;

    assign fire = din && (run_q == RW'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst || fire || !din) run_q <= '0;
        else                     run_q <= run_q + 1'b1;
    end
endmodule

// File: rtl/sif_regfile.sv
module sif_regfile
    import sif_pkg::*;
(
    input  logic              clk,
    input  logic              rst_all,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [2:0]        rd_addr,
    input  logic              rd_evt,
    input  logic              conv_load,
    input  logic [DATA_W-1:0] conv_data,
    output logic [DATA_W-1:0] rd_val,
    output logic              rdy_n,
    output logic [15:0]       mode_q,
    output logic [15:0]       conf_q,
    output logic [23:0]       offs_q,
    output logic [23:0]       fscale_q
);
    logic [DATA_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst_all) begin
            mode_q   <= MODE_DEF;
            conf_q   <= CONF_DEF;
            offs_q   <= OFFS_DEF;
            fscale_q <= FSCL_DEF;
            data_q   <= '0;
            rdy_n    <= 1'b1;
        end else begin
            if (wr_en) begin
                case (wr_addr)
                    A_MODE:  mode_q   <= wr_data[15:0];
                    A_CONF:  conf_q   <= wr_data[15:0];
                    A_OFFS:  offs_q   <= wr_data;
                    A_FSCL:  fscale_q <= wr_data;
                    default: ;
                endcase
            end
            if (conv_load) begin
                data_q <= conv_data;
                rdy_n  <= 1'b0;
            end else if (rd_evt) begin
                rdy_n  <= 1'b1;
            end
        end
    end

    always_comb begin
        case (rd_addr)
            A_COMM:  rd_val = {16'h0, rdy_n, 7'h0};
            A_MODE:  rd_val = {8'h0, mode_q};
            A_CONF:  rd_val = {8'h0, conf_q};
            A_DATA:  rd_val = data_q;
            A_IDENT: rd_val = {16'h0, IDENT_VAL};
            A_OFFS:  rd_val = offs_q;
            A_FSCL:  rd_val = fscale_q;
            default: rd_val = '0;
        endcase
    end
endmodule

// File: rtl/sercmd_if.sv
module sercmd_if
    import sif_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              din,
    input  logic              conv_load,
    input  logic [DATA_W-1:0] conv_data,
    output logic              dout,
    output logic              rdy_n,
    output logic [15:0]       mode_q,
    output logic [15:0]       conf_q,
    output logic [23:0]       offs_q,
    output logic [23:0]       fscale_q
);
    state_e            state_q;
    logic [CNT_W-1:0]  cnt_q, len_q;
    logic [DATA_W-2:0] rx_q;
    logic [DATA_W-1:0] tx_q, rd_val, wr_word;
    logic [2:0]        addr_q, rd_sel;
    logic              exit_q, ones_fire, rst_all, wr_en, rd_evt, cmd_done, last_bit;
    cmd_t              cmd_now;
    logic [CNT_W-1:0]  cmd_len;

    assign rst_all = rst || ones_fire;

    sif_ones_watch #(.RUN_LEN(RUN_LEN)) ones_i (
        .clk(clk), .rst(rst), .din(din), .fire(ones_fire)
    );

    always_comb begin
        cmd_now  = cmd_t'({rx_q[CMD_W-2:0], din});
        wr_word  = {rx_q, din};
        cmd_len  = reg_bits(cmd_now.addr);
        cmd_done = (state_q == S_CMD) && (cnt_q == CNT_W'(CMD_W - 1));
        last_bit = (cnt_q == len_q - 1'b1);
        wr_en    = (state_q == S_WR) && last_bit;
        rd_sel   = (state_q == S_CRWAIT) ? A_DATA : cmd_now.addr;
        rd_evt   = (cmd_done && cmd_now.rd && cmd_now.addr == A_DATA &&
                    cmd_now != cmd_t'(CREAD_ENTER)) ||
                   (state_q == S_CRWAIT && !rdy_n);
    end

    sif_regfile regs_i (
        .clk(clk), .rst_all(rst_all), .wr_en(wr_en), .wr_addr(addr_q),
        .wr_data(wr_word), .rd_addr(rd_sel), .rd_evt(rd_evt),
        .conv_load(conv_load), .conv_data(conv_data), .rd_val(rd_val),
        .rdy_n(rdy_n), .mode_q(mode_q), .conf_q(conf_q), .offs_q(offs_q),
        .fscale_q(fscale_q)
    );

    always_ff @(posedge clk) begin
        if (rst_all) begin
            state_q <= S_CMD;
            cnt_q   <= '0;
            len_q   <= '0;
            rx_q    <= '0;
            tx_q    <= '0;
            addr_q  <= '0;
            exit_q  <= 1'b0;
        end else begin
            case (state_q)
                S_CMD: begin
                    if (cnt_q != '0 || !din) begin
                        rx_q <= wr_word[DATA_W-2:0];
                        if (cmd_done) begin
                            cnt_q  <= '0;
                            addr_q <= cmd_now.addr;
                            len_q  <= cmd_len;
                            if (cmd_now == cmd_t'(CREAD_ENTER)) begin
                                state_q <= S_CRWAIT;
                            end else if (cmd_now.rd) begin
                                tx_q    <= rd_val << (CNT_W'(DATA_W) - cmd_len);
                                state_q <= S_RD;
                            end else if (cmd_now.addr != A_COMM) begin
                                state_q <= S_WR;
                            end
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                S_WR, S_RD: begin
                    rx_q <= wr_word[DATA_W-2:0];
                    tx_q <= tx_q << 1;
                    if (last_bit) begin
                        cnt_q   <= '0;
                        state_q <= S_CMD;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                S_CRWAIT: begin
                    if (!rdy_n) begin
                        tx_q    <= rd_val;
                        cnt_q   <= '0;
                        len_q   <= CNT_W'(DATA_W);
                        exit_q  <= 1'b0;
                        state_q <= S_CRRD;
                    end
                end
                S_CRRD: begin
                    rx_q <= wr_word[DATA_W-2:0];
                    tx_q <= tx_q << 1;
                    if (cnt_q == CNT_W'(CMD_W - 1) && cmd_now == cmd_t'(CREAD_LEAVE))
                        exit_q <= 1'b1;
                    if (last_bit) begin
                        cnt_q   <= '0;
                        state_q <= exit_q ? S_CMD : S_CRWAIT;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: state_q <= S_CMD;
            endcase
        end
    end

    always_ff @(negedge clk) begin
        if (rst) dout <= 1'b0;
        else     dout <= (state_q == S_RD || state_q == S_CRRD) ? tx_q[DATA_W-1] : 1'b0;
    end
endmodule

// File: rtl/sercmd_if_chk.sv
module sercmd_if_chk
    import sif_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             din,
    input logic             rdy_n,
    input logic             conv_load,
    input logic             fire,
    input logic [15:0]      mode_q,
    input logic [23:0]      fscale_q,
    input state_e           st,
    input logic [CNT_W-1:0] cnt
);
    assert_wen_hold_R1: assert property (@(posedge clk) disable iff (rst)
        (st == S_CMD && cnt == '0 && din) |=> (st == S_CMD && cnt == '0));

    assert_write_only_in_phase_R5: assert property (@(posedge clk) disable iff (rst)
        (st != S_WR && !fire) |=> $stable(fscale_q));

    assert_load_ready_R7: assert property (@(posedge clk) disable iff (rst)
        (conv_load && !fire) |=> !rdy_n);

    assert_ones_reset_R10: assert property (@(posedge clk) disable iff (rst)
        fire |=> (mode_q == MODE_DEF && rdy_n && st == S_CMD));

    assert_reset_state_R11: assert property (@(posedge clk)
        rst |=> (rdy_n && st == S_CMD && cnt == '0));
endmodule

bind sercmd_if sercmd_if_chk chk_i (
    .clk(clk), .rst(rst), .din(din), .rdy_n(rdy_n), .conv_load(conv_load),
    .fire(ones_fire), .mode_q(mode_q), .fscale_q(fscale_q), .st(state_q),
    .cnt(cnt_q)
);

// File: tb/sercmd_if_tb_top.sv
module sercmd_if_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        din = 1'b1;
    logic        conv_load = 1'b0;
    logic [23:0] conv_data = '0;
    logic        dout, rdy_n;
    logic [15:0] mode_q, conf_q;
    logic [23:0] offs_q, fscale_q;
    int total = 0;
    int bad   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;

    sercmd_if dut_i (
        .clk(clk), .rst(rst), .din(din), .conv_load(conv_load), .conv_data(conv_data),
        .dout(dout), .rdy_n(rdy_n), .mode_q(mode_q), .conf_q(conf_q),
        .offs_q(offs_q), .fscale_q(fscale_q)
    );

    // stimulus table: {addr, value}
    localparam logic [26:0] VEC [6] = '{
        {3'd1, 24'h001234}, {3'd2, 24'h00A5C3}, {3'd6, 24'h123456},
        {3'd7, 24'hFEDCBA}, {3'd5, 24'h0000FF}, {3'd1, 24'h00BEEF}
    };

    function automatic int bw(input logic [2:0] a);
        if (a == 3'd1 || a == 3'd2) return 16;
        if (a == 3'd3 || a >= 3'd6) return 24;
        return 8;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic b, output logic o);
        @(negedge clk);
        #2 din = b;
        #6 o = dout;
        @(posedge clk);
    endtask

    task automatic send_byte(input logic [7:0] c);
        logic o;
        for (int i = 7; i >= 0; i--) xfer(c[i], o);
    endtask

    task automatic write_reg(input logic [2:0] a, input logic [23:0] v);
        logic o;
        send_byte({2'b00, a, 3'b000});
        for (int i = bw(a) - 1; i >= 0; i--) xfer(v[i], o);
    endtask

    task automatic read_reg(input logic [2:0] a, output logic [23:0] v);
        logic o;
        send_byte({2'b01, a, 3'b000});
        v = '0;
        for (int i = 0; i < bw(a); i++) begin
            xfer(1'b1, o);
            v = {v[22:0], o};
        end
    endtask

    task automatic pulse_load(input logic [23:0] v, input logic idle_b);
        @(negedge clk);
        #2 din = idle_b; conv_load = 1'b1; conv_data = v;
        @(posedge clk);
        #1 conv_load = 1'b0;
    endtask

    task automatic cread_frame(input logic [23:0] in_bits, output logic [23:0] v);
        logic o;
        xfer(1'b0, o);
        v = '0;
        for (int i = 23; i >= 0; i--) begin
            xfer(in_bits[i], o);
            v = {v[22:0], o};
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=%h expected=%h", 1'b1, 1'b0);
        finish_up();
    end

    initial begin
        logic [23:0] r;
        logic o;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R11 reset state
        check("R11 rdy_n", {23'h0, rdy_n}, 24'h1);
        check("R11 dout", {23'h0, dout}, 24'h0);
        check("R11 mode", {8'h0, mode_q}, 24'h00000A);
        check("R11 conf", {8'h0, conf_q}, 24'h000710);
        check("R11 offset", offs_q, 24'h800000);
        check("R11 fullscale", fscale_q, 24'h500000);

        // R1: leading ones hold the first position, then ID read
        for (int i = 0; i < 5; i++) xfer(1'b1, o);
        read_reg(3'd4, r);
        check("R1 R4 ident after leading ones", r, 24'h00005B);
        read_reg(3'd0, r);
        check("R4 status idle", r, 24'h000080);
        read_reg(3'd5, r);
        check("R4 reserved read", r, 24'h0);

        // R2 R3 R6 table of back-to-back writes and read-backs
        for (int k = 0; k < 6; k++) begin
            logic [2:0]  a;
            logic [23:0] v;
            a = VEC[k][26:24];
            v = VEC[k][23:0];
            write_reg(a, v);
            read_reg(a, r);
            check("R2 R3 R6 readback", r, (a == 3'd5) ? 24'h0 : v);
            if (a == 3'd5) begin
                check("R5 reserved write fullscale", fscale_q, 24'hFEDCBA);
                check("R5 reserved write offset", offs_q, 24'h123456);
            end
        end
        check("R2 mode port", {8'h0, mode_q}, 24'h00BEEF);
        check("R2 conf port", {8'h0, conf_q}, 24'h00A5C3);
        send_byte(8'h00);
        read_reg(3'd4, r);
        check("R5 command-only write", r, 24'h00005B);

        // R7 conversion load and data read
        pulse_load(24'hABCDEF, 1'b1);
        #1 check("R7 rdy_n low after load", {23'h0, rdy_n}, 24'h0);
        read_reg(3'd0, r);
        check("R4 status ready", r, 24'h0);
        read_reg(3'd3, r);
        check("R3 R7 data read", r, 24'hABCDEF);
        #1 check("R7 rdy_n high after read", {23'h0, rdy_n}, 24'h1);

        // R8 continuous read
        send_byte(8'h5C);
        for (int i = 0; i < 4; i++) xfer(1'b0, o);
        check("R8 idle dout with ready high", {23'h0, o}, 24'h0);
        pulse_load(24'h13579B, 1'b0);
        cread_frame(24'h0, r);
        check("R8 frame one", r, 24'h13579B);
        check("R7 rdy_n high in cread", {23'h0, rdy_n}, 24'h1);
        for (int i = 0; i < 3; i++) xfer(1'b0, o);
        pulse_load(24'h2468AC, 1'b0);
        cread_frame(24'h0, r);
        check("R8 frame two", r, 24'h2468AC);
        // R9 exit command inside a frame
        pulse_load(24'hC0FFEE, 1'b0);
        cread_frame({8'h58, 16'h0}, r);
        check("R9 exit frame data", r, 24'hC0FFEE);
        read_reg(3'd4, r);
        check("R9 command after exit", r, 24'h00005B);

        // R10 31 ones do not reset, 32 do
        write_reg(3'd1, 24'h001234);
        for (int i = 0; i < 31; i++) xfer(1'b1, o);
        read_reg(3'd1, r);
        check("R10 31 ones no reset", r, 24'h001234);
        send_byte(8'h00);
        for (int i = 0; i < 32; i++) xfer(1'b1, o);
        #1 check("R10 32 ones reset mode", {8'h0, mode_q}, 24'h00000A);
        // R10 from inside continuous read
        write_reg(3'd7, 24'h0A0B0C);
        send_byte(8'h5C);
        for (int i = 0; i < 32; i++) xfer(1'b1, o);
        #1 check("R10 cread reset fullscale", fscale_q, 24'h500000);
        read_reg(3'd4, r);
        check("R10 command after cread reset", r, 24'h00005B);

        finish_up();
    end
endmodule